// File: doc/BRIEF.md
# Per-Thread Commit Squash Controller

This block sits in the commit stage of an out-of-order core and decides, once per cycle and separately for each hardware thread, whether that thread's in-flight work must be thrown away and from which point. Four kinds of request can cause a squash. The first is a trap request, which only takes effect after a programmable delay. The second is a thread-context squash from outside the core. The third is a squash-after request that commit raises for an instruction that must run alone. The fourth is a squash from the execute stage, which carries a sequence number and a redirect address.

When a squash is chosen, the block sends a registered bundle back to the earlier stages. The bundle holds a squash pulse, a reorder-buffer-squashing flag, the done sequence number (the oldest surviving instruction), a redirect PC and a branch-taken flag. The squash pulse together with the done sequence number is also the command to the reorder buffer. The buffer answers with a done-squashing input. The block itself does not hold the reorder buffer. It only watches the buffer's empty flag, the buffer's head sequence number, the newest inserted sequence number and the last committed sequence number for each thread.

Each thread has its own state machine with these states, encoded on `thr_state`: IDLE=0, RUN=1, ROBSQ=2 (reorder buffer squashing), TRAP=3 (trap pending) and SAPEND=4 (squash-after pending). The transitions are:
- enable: IDLE to RUN when the thread's enable is high.
- squash: from RUN, ROBSQ, TRAP or SAPEND to ROBSQ on any accepted squash.
- trap accept: to TRAP when a trap request is taken.
- squash-after accept: RUN to SAPEND.
- done: ROBSQ to RUN when the buffer reports that squashing is finished.

Top module: `squash_ctl`

## Requirements
- R1: After reset every thread is in IDLE (0). The squash pulse, reorder-buffer-squashing flag, branch-taken flag, error flag, done sequence, redirect PC and mispredict count are all zero.
- R2: A thread in IDLE ignores every request and raises no squash. A high enable moves it to RUN (1) at the next edge.
- R3: A trap request that is accepted (thread not IDLE, no trap already in flight, no squash chosen that cycle) moves the thread to TRAP (3) at the same edge. If it is taken at edge k with latency L≥1, the trap squash is sent at edge k+L.
- R4: An execute squash is accepted only when the thread is not in TRAP and its raw sequence number is less than or equal to the thread's youngest sequence. The youngest sequence is the last inserted number, or the last squash sequence if that is more recent.
- R5: An accepted execute squash uses the supplied sequence number, or that number minus one when the include-self flag is set. It redirects to the supplied PC, and the youngest sequence becomes the squash sequence.
- R6: At the edge of any accepted squash, the squash pulse and the reorder-buffer-squashing flag are both 1. The done sequence holds the squash sequence, and the state becomes ROBSQ (2).
- R7: An accepted execute squash that is marked mispredicted adds one to that thread's mispredict count. The branch-taken output is the supplied taken bit, forced to 1 when the mispredicted instruction is an unconditional control transfer.
- R8: While the thread is in ROBSQ and done-squashing is low, the reorder-buffer-squashing flag is 1 at the next edge. When done-squashing is high, the thread goes to RUN and the flag drops.
- R9: A trap, thread-context or squash-after squash removes everything. Its sequence number is the last committed number when the buffer is empty, and otherwise the buffer head number minus one. It redirects to the thread's architectural PC.
- R10: Sources are ranked: a matured trap first, then a thread-context squash, then a pending squash-after, then an execute squash. Only the winner acts.
- R11: A thread-context squash that arrives while a trap is in flight raises the error flag for one cycle. It is otherwise ignored, and the thread stays in TRAP.
- R12: A squash-after request in RUN moves the thread to SAPEND (4) with no squash. The remove-all squash follows at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_lat | input | LATW | Trap delay in cycles (0 acts as 1) |
| thr_en | input | NT | Thread enable (leave IDLE) |
| trap_req | input | NT | Trap request |
| tc_req | input | NT | Thread-context squash request |
| sa_req | input | NT | Squash-after request from commit |
| ex_vld | input | NT | Execute squash valid |
| ex_seq | input | NT*SEQW | Execute squash sequence number |
| ex_incl | input | NT | Include the squashing instruction |
| ex_pc | input | NT*PCW | Execute redirect PC |
| ex_mispred | input | NT | Squash is a branch mispredict |
| ex_uncond | input | NT | Mispredicted instruction is unconditional |
| ex_taken | input | NT | Branch taken bit from execute |
| ins_vld | input | NT | Instruction inserted this cycle |
| ins_seq | input | NT*SEQW | Sequence number of inserted instruction |
| cmt_vld | input | NT | Instruction committed this cycle |
| cmt_seq | input | NT*SEQW | Sequence number of committed instruction |
| rob_empty | input | NT | Thread's reorder buffer is empty |
| rob_head | input | NT*SEQW | Head sequence number of the buffer |
| rob_done | input | NT | Buffer finished squashing |
| arch_pc | input | NT*PCW | Restart PC for remove-all squashes |
| sq_out | output | NT | Squash pulse / buffer squash command |
| rob_sq_out | output | NT | Buffer-squashing flag |
| done_seq | output | NT*SEQW | Squash sequence number |
| redir_pc | output | NT*PCW | Redirect PC |
| br_taken | output | NT | Branch-taken flag |
| tc_err | output | NT | Thread-context squash during trap |
| mp_cnt | output | NT*CNTW | Mispredict count |
| thr_state | output | NT*3 | Thread state encoding |

## Verification
The assertions check, on every cycle, the relations that hold between registered outputs. A squash pulse always comes with the buffer-squashing flag and the ROBSQ state. The branch-taken flag only appears with a squash. An IDLE thread never squashes. A ROBSQ thread keeps the flag up until the buffer reports done, and then leaves. Only the bench scenarios can show the rest: the exact trap delay, the sequence arithmetic for the include-self and remove-all cases, the accept/reject decision against the youngest sequence, the priority between simultaneous sources, the error flag, and the mispredict count.

// File: rtl/squash_pkg.sv
package squash_pkg;
    typedef enum logic [2:0] {
        TS_IDLE   = 3'd0,
        TS_RUN    = 3'd1,
        TS_ROBSQ  = 3'd2,
        TS_TRAP   = 3'd3,
        TS_SAPEND = 3'd4
    } thr_st_e;
endpackage

// File: rtl/sq_trap_timer.sv
module sq_trap_timer #(
    parameter int LATW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            fire,
    input  logic [LATW-1:0] lat,
    output logic            in_flight,
    output logic            matured
);
    logic [LATW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight <= 1'b0;
            cnt_q     <= '0;
        end else if (start) begin
            in_flight <= 1'b1;
            cnt_q     <= (lat == '0) ? '0 : lat - LATW'(1);
        end else if (fire) begin
            in_flight <= 1'b0;
        end else if (in_flight && cnt_q != '0) begin
            cnt_q <= cnt_q - LATW'(1);
        end
    end

    assign matured = in_flight && (cnt_q == '0);
endmodule

// File: rtl/sq_src_arb.sv
module sq_src_arb
    import squash_pkg::*;
#(
    parameter int SEQW = 32
) (
    input  thr_st_e         st,
    input  logic            trap_fl,
    input  logic            trap_mat,
    input  logic            trap_req,
    input  logic            tc_req,
    input  logic            sa_req,
    input  logic            ex_vld,
    input  logic [SEQW-1:0] ex_seq,
    input  logic            ex_incl,
    input  logic [SEQW-1:0] young,
    input  logic            rob_empty,
    input  logic [SEQW-1:0] last_cmt,
    input  logic [SEQW-1:0] rob_head,
    output logic            do_trap,
    output logic            do_tc,
    output logic            do_sa,
    output logic            ex_ok,
    output logic            any_sq,
    output logic            tc_bad,
    output logic            take_trap,
    output logic            take_sa,
    output logic [SEQW-1:0] sq_seq
);
    logic            active;
    logic [SEQW-1:0] all_seq;

    always_comb begin
        active    = (st != TS_IDLE);
        do_trap   = active && trap_mat;
        tc_bad    = active && tc_req && trap_fl;
        do_tc     = active && tc_req && !trap_fl && !do_trap;
        do_sa     = active && !do_trap && !do_tc && (st == TS_SAPEND);
        ex_ok     = active && !do_trap && !do_tc && !do_sa && ex_vld &&
                    (st != TS_TRAP) && (ex_seq <= young);
        any_sq    = do_trap || do_tc || do_sa || ex_ok;
        take_trap = active && trap_req && !trap_fl && !any_sq;
        take_sa   = (st == TS_RUN) && sa_req && !any_sq && !take_trap;
        all_seq   = rob_empty ? last_cmt : rob_head - SEQW'(1);
        if (ex_ok)
            sq_seq = ex_incl ? ex_seq - SEQW'(1) : ex_seq;
        else
            sq_seq = all_seq;
    end
endmodule

// File: rtl/sq_thread.sv
module sq_thread
    import squash_pkg::*;
#(
    parameter int SEQW = 32,
    parameter int PCW  = 32,
    parameter int LATW = 8,
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LATW-1:0] trap_lat,
    input  logic            thr_en,
    input  logic            trap_req,
    input  logic            tc_req,
    input  logic            sa_req,
    input  logic            ex_vld,
    input  logic [SEQW-1:0] ex_seq,
    input  logic            ex_incl,
    input  logic [PCW-1:0]  ex_pc,
    input  logic            ex_mispred,
    input  logic            ex_uncond,
    input  logic            ex_taken,
    input  logic            ins_vld,
    input  logic [SEQW-1:0] ins_seq,
    input  logic            cmt_vld,
    input  logic [SEQW-1:0] cmt_seq,
    input  logic            rob_empty,
    input  logic [SEQW-1:0] rob_head,
    input  logic            rob_done,
    input  logic [PCW-1:0]  arch_pc,
    output logic            sq_out,
    output logic            rob_sq_out,
    output logic [SEQW-1:0] done_seq,
    output logic [PCW-1:0]  redir_pc,
    output logic            br_taken,
    output logic            tc_err,
    output logic [CNTW-1:0] mp_cnt,
    output logic [2:0]      state
);
    thr_st_e         st_q, st_d;
    logic            trap_fl, trap_mat;
    logic            do_trap, do_tc, do_sa, ex_ok, any_sq, tc_bad, take_trap, take_sa;
    logic [SEQW-1:0] sq_seq, young_q, last_cmt_q;

    sq_trap_timer #(.LATW(LATW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take_trap),
        .fire      (do_trap),
        .lat       (trap_lat),
        .in_flight (trap_fl),
        .matured   (trap_mat)
    );

    sq_src_arb #(.SEQW(SEQW)) u_arb (
        .st        (st_q),
        .trap_fl   (trap_fl),
        .trap_mat  (trap_mat),
        .trap_req  (trap_req),
        .tc_req    (tc_req),
        .sa_req    (sa_req),
        .ex_vld    (ex_vld),
        .ex_seq    (ex_seq),
        .ex_incl   (ex_incl),
        .young     (young_q),
        .rob_empty (rob_empty),
        .last_cmt  (last_cmt_q),
        .rob_head  (rob_head),
        .do_trap   (do_trap),
        .do_tc     (do_tc),
        .do_sa     (do_sa),
        .ex_ok     (ex_ok),
        .any_sq    (any_sq),
        .tc_bad    (tc_bad),
        .take_trap (take_trap),
        .take_sa   (take_sa),
        .sq_seq    (sq_seq)
    );

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE: if (thr_en) st_d = TS_RUN;
            TS_RUN, TS_ROBSQ, TS_TRAP, TS_SAPEND: begin
                if (any_sq)                            st_d = TS_ROBSQ;
                else if (take_trap)                    st_d = TS_TRAP;
                else if (take_sa)                      st_d = TS_SAPEND;
                else if (st_q == TS_ROBSQ && rob_done) st_d = TS_RUN;
            end
            default: st_d = TS_IDLE;
        endcase
    end

    // state register and tracked sequence numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= TS_IDLE;
            young_q    <= '0;
            last_cmt_q <= '0;
        end else begin
            st_q <= st_d;
            if (any_sq)       young_q <= sq_seq;
            else if (ins_vld) young_q <= ins_seq;
            if (cmt_vld)      last_cmt_q <= cmt_seq;
        end
    end

    // registered broadcast bundle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_out     <= 1'b0;
            rob_sq_out <= 1'b0;
            done_seq   <= '0;
            redir_pc   <= '0;
            br_taken   <= 1'b0;
            tc_err     <= 1'b0;
            mp_cnt     <= '0;
        end else begin
            sq_out     <= any_sq;
            rob_sq_out <= any_sq || (st_q == TS_ROBSQ && !rob_done);
            br_taken   <= ex_ok && (ex_taken || (ex_mispred && ex_uncond));
            tc_err     <= tc_bad;
            if (any_sq) begin
                done_seq <= sq_seq;
                redir_pc <= ex_ok ? ex_pc : arch_pc;
            end
            if (ex_ok && ex_mispred) mp_cnt <= mp_cnt + CNTW'(1);
        end
    end

    assign state = st_q;
endmodule

// File: rtl/squash_ctl.sv
module squash_ctl #(
    parameter int NT   = 2,
    parameter int SEQW = 32,
    parameter int PCW  = 32,
    parameter int LATW = 8,
    parameter int CNTW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LATW-1:0]          trap_lat,
    input  logic [NT-1:0]            thr_en,
    input  logic [NT-1:0]            trap_req,
    input  logic [NT-1:0]            tc_req,
    input  logic [NT-1:0]            sa_req,
    input  logic [NT-1:0]            ex_vld,
    input  logic [NT-1:0][SEQW-1:0]  ex_seq,
    input  logic [NT-1:0]            ex_incl,
    input  logic [NT-1:0][PCW-1:0]   ex_pc,
    input  logic [NT-1:0]            ex_mispred,
    input  logic [NT-1:0]            ex_uncond,
    input  logic [NT-1:0]            ex_taken,
    input  logic [NT-1:0]            ins_vld,
    input  logic [NT-1:0][SEQW-1:0]  ins_seq,
    input  logic [NT-1:0]            cmt_vld,
    input  logic [NT-1:0][SEQW-1:0]  cmt_seq,
    input  logic [NT-1:0]            rob_empty,
    input  logic [NT-1:0][SEQW-1:0]  rob_head,
    input  logic [NT-1:0]            rob_done,
    input  logic [NT-1:0][PCW-1:0]   arch_pc,
    output logic [NT-1:0]            sq_out,
    output logic [NT-1:0]            rob_sq_out,
    output logic [NT-1:0][SEQW-1:0]  done_seq,
    output logic [NT-1:0][PCW-1:0]   redir_pc,
    output logic [NT-1:0]            br_taken,
    output logic [NT-1:0]            tc_err,
    output logic [NT-1:0][CNTW-1:0]  mp_cnt,
    output logic [NT-1:0][2:0]       thr_state
);
    for (genvar t = 0; t < NT; t++) begin : g_thr
        sq_thread #(.SEQW(SEQW), .PCW(PCW), .LATW(LATW), .CNTW(CNTW)) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .trap_lat   (trap_lat),
            .thr_en     (thr_en[t]),
            .trap_req   (trap_req[t]),
            .tc_req     (tc_req[t]),
            .sa_req     (sa_req[t]),
            .ex_vld     (ex_vld[t]),
            .ex_seq     (ex_seq[t]),
            .ex_incl    (ex_incl[t]),
            .ex_pc      (ex_pc[t]),
            .ex_mispred (ex_mispred[t]),
            .ex_uncond  (ex_uncond[t]),
            .ex_taken   (ex_taken[t]),
            .ins_vld    (ins_vld[t]),
            .ins_seq    (ins_seq[t]),
            .cmt_vld    (cmt_vld[t]),
            .cmt_seq    (cmt_seq[t]),
            .rob_empty  (rob_empty[t]),
            .rob_head   (rob_head[t]),
            .rob_done   (rob_done[t]),
            .arch_pc    (arch_pc[t]),
            .sq_out     (sq_out[t]),
            .rob_sq_out (rob_sq_out[t]),
            .done_seq   (done_seq[t]),
            .redir_pc   (redir_pc[t]),
            .br_taken   (br_taken[t]),
            .tc_err     (tc_err[t]),
            .mp_cnt     (mp_cnt[t]),
            .state      (thr_state[t])
        );
    end
endmodule

// File: rtl/squash_ctl_chk.sv
module squash_ctl_chk #(
    parameter int NT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NT-1:0][2:0]  thr_state,
    input logic [NT-1:0]       sq_out,
    input logic [NT-1:0]       rob_sq_out,
    input logic [NT-1:0]       br_taken,
    input logic [NT-1:0]       rob_done
);
    for (genvar t = 0; t < NT; t++) begin : g_chk
        AST_SQ_GOES_ROBSQ: assert property (@(posedge clk) disable iff (!rst_n)
            sq_out[t] |-> (thr_state[t] == 3'd2 && rob_sq_out[t])); // R6
        AST_TAKEN_NEEDS_SQ: assert property (@(posedge clk) disable iff (!rst_n)
            br_taken[t] |-> sq_out[t]); // R7
        AST_IDLE_NO_SQ: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 3'd0) |=> !sq_out[t]); // R2
        AST_ROBSQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 3'd2 && !rob_done[t]) |=> rob_sq_out[t]); // R8
        AST_ROBSQ_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_state[t] == 3'd2 && rob_done[t]) |=> (thr_state[t] != 3'd2 || sq_out[t])); // R8
    end
endmodule

bind squash_ctl squash_ctl_chk #(.NT(NT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .thr_state  (thr_state),
    .sq_out     (sq_out),
    .rob_sq_out (rob_sq_out),
    .br_taken   (br_taken),
    .rob_done   (rob_done)
);

// File: tb/squash_ctl_tb.sv
module squash_ctl_tb;
    localparam int NT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0]           trap_lat;
    logic [NT-1:0]        thr_en, trap_req, tc_req, sa_req, ex_vld, ex_incl;
    logic [NT-1:0]        ex_mispred, ex_uncond, ex_taken, ins_vld, cmt_vld;
    logic [NT-1:0]        rob_empty, rob_done;
    logic [NT-1:0][31:0]  ex_seq, ex_pc, ins_seq, cmt_seq, rob_head, arch_pc;
    logic [NT-1:0]        sq_out, rob_sq_out, br_taken, tc_err;
    logic [NT-1:0][31:0]  done_seq, redir_pc;
    logic [NT-1:0][15:0]  mp_cnt;
    logic [NT-1:0][2:0]   thr_state;

    squash_ctl #(.NT(NT)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_lat(trap_lat), .thr_en(thr_en),
        .trap_req(trap_req), .tc_req(tc_req), .sa_req(sa_req), .ex_vld(ex_vld),
        .ex_seq(ex_seq), .ex_incl(ex_incl), .ex_pc(ex_pc), .ex_mispred(ex_mispred),
        .ex_uncond(ex_uncond), .ex_taken(ex_taken), .ins_vld(ins_vld), .ins_seq(ins_seq),
        .cmt_vld(cmt_vld), .cmt_seq(cmt_seq), .rob_empty(rob_empty), .rob_head(rob_head),
        .rob_done(rob_done), .arch_pc(arch_pc), .sq_out(sq_out), .rob_sq_out(rob_sq_out),
        .done_seq(done_seq), .redir_pc(redir_pc), .br_taken(br_taken), .tc_err(tc_err),
        .mp_cnt(mp_cnt), .thr_state(thr_state)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_pulses();
        trap_req = '0; tc_req = '0; sa_req = '0; ex_vld = '0; ex_incl = '0;
        ex_mispred = '0; ex_uncond = '0; ex_taken = '0; ins_vld = '0;
        cmt_vld = '0; rob_done = '0;
    endtask

    task automatic finish_sq(input string tag);
        rob_done[0] = 1'b1;
        step();
        rob_done[0] = 1'b0;
        chk({tag, " state back to RUN"}, 32'(thr_state[0]), 32'd1);
        chk({tag, " rob_sq dropped"}, 32'(rob_sq_out[0]), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 state", 32'(thr_state[0]), 32'd0);
        chk("R1 sq", 32'(sq_out), 32'd0);
        chk("R1 rob_sq", 32'(rob_sq_out), 32'd0);
        chk("R1 done_seq", done_seq[0], 32'd0);
        chk("R1 mp_cnt", 32'(mp_cnt[0]), 32'd0);
    endtask

    task automatic t_idle();
        ex_vld[0] = 1'b1; ex_seq[0] = 32'd0; tc_req[1] = 1'b1;
        step();
        clear_pulses();
        chk("R2 idle no squash", 32'(sq_out), 32'd0);
        chk("R2 idle state", 32'(thr_state[0]), 32'd0);
        thr_en = '1;
        step();
        chk("R2 enable to RUN", 32'(thr_state[0]), 32'd1);
        ins_vld[0] = 1'b1; ins_seq[0] = 32'd100;
        cmt_vld[0] = 1'b1; cmt_seq[0] = 32'd30;
        step();
        clear_pulses();
    endtask

    task automatic t_exec();
        ex_vld[0] = 1'b1; ex_seq[0] = 32'd50; ex_pc[0] = 32'h1000;
        step();
        clear_pulses();
        chk("R6 sq pulse", 32'(sq_out[0]), 32'd1);
        chk("R6 rob_sq", 32'(rob_sq_out[0]), 32'd1);
        chk("R5 done seq", done_seq[0], 32'd50);
        chk("R5 redirect", redir_pc[0], 32'h1000);
        chk("R6 state ROBSQ", 32'(thr_state[0]), 32'd2);
        step();
        chk("R8 rob_sq held", 32'(rob_sq_out[0]), 32'd1);
        chk("R8 sq one pulse", 32'(sq_out[0]), 32'd0);
        step();
        chk("R8 rob_sq held again", 32'(rob_sq_out[0]), 32'd1);
        finish_sq("R8");
        ex_vld[0] = 1'b1; ex_seq[0] = 32'd60;
        step();
        clear_pulses();
        chk("R4 younger rejected", 32'(sq_out[0]), 32'd0);
        ex_vld[0] = 1'b1; ex_seq[0] = 32'd50; ex_incl[0] = 1'b1;
        step();
        clear_pulses();
        chk("R5 include self", done_seq[0], 32'd49);
        chk("R4 equal accepted", 32'(sq_out[0]), 32'd1);
        finish_sq("R5");
        chk("R2 other thread quiet", 32'(sq_out[1]), 32'd0);
    endtask

    task automatic t_mispred();
        ex_vld[0] = 1'b1; ex_seq[0] = 32'd40; ex_mispred[0] = 1'b1;
        ex_uncond[0] = 1'b1; ex_taken[0] = 1'b0;
        step();
        clear_pulses();
        chk("R7 uncond forces taken", 32'(br_taken[0]), 32'd1);
        chk("R7 count 1", 32'(mp_cnt[0]), 32'd1);
        finish_sq("R7");
        ex_vld[0] = 1'b1; ex_seq[0] = 32'd40; ex_mispred[0] = 1'b1;
        step();
        clear_pulses();
        chk("R7 cond not taken", 32'(br_taken[0]), 32'd0);
        chk("R7 count 2", 32'(mp_cnt[0]), 32'd2);
        finish_sq("R7");
    endtask

    task automatic t_trap();
        trap_lat = 8'd3; rob_empty[0] = 1'b1; arch_pc[0] = 32'h2000;
        trap_req[0] = 1'b1;
        step();
        clear_pulses();
        chk("R3 state TRAP", 32'(thr_state[0]), 32'd3);
        chk("R3 no squash yet", 32'(sq_out[0]), 32'd0);
        ex_vld[0] = 1'b1; ex_seq[0] = 32'd10;
        step();
        clear_pulses();
        chk("R4 exec rejected in TRAP", 32'(sq_out[0]), 32'd0);
        step();
        chk("R3 still waiting", 32'(sq_out[0]), 32'd0);
        step();
        chk("R3 trap squash at latency", 32'(sq_out[0]), 32'd1);
        chk("R9 empty uses last commit", done_seq[0], 32'd30);
        chk("R9 arch pc", redir_pc[0], 32'h2000);
        finish_sq("R3");
    endtask

    task automatic t_tc_prio();
        rob_empty[0] = 1'b0; rob_head[0] = 32'd80;
        tc_req[0] = 1'b1; ex_vld[0] = 1'b1; ex_seq[0] = 32'd5;
        step();
        clear_pulses();
        chk("R10 tc beats exec", done_seq[0], 32'd79);
        chk("R9 head minus one pc", redir_pc[0], 32'h2000);
        finish_sq("R10");
    endtask

    task automatic t_tc_err();
        trap_req[0] = 1'b1;
        step();
        clear_pulses();
        tc_req[0] = 1'b1;
        step();
        clear_pulses();
        chk("R11 error flag", 32'(tc_err[0]), 32'd1);
        chk("R11 ignored", 32'(sq_out[0]), 32'd0);
        chk("R11 stays TRAP", 32'(thr_state[0]), 32'd3);
        step();
        chk("R11 error one cycle", 32'(tc_err[0]), 32'd0);
        step();
        chk("R10 trap squash", 32'(sq_out[0]), 32'd1);
        finish_sq("R11");
    endtask

    task automatic t_sa();
        rob_head[0] = 32'd90;
        sa_req[0] = 1'b1;
        step();
        clear_pulses();
        chk("R12 SAPEND", 32'(thr_state[0]), 32'd4);
        chk("R12 no squash yet", 32'(sq_out[0]), 32'd0);
        step();
        chk("R12 squash follows", 32'(sq_out[0]), 32'd1);
        chk("R12 seq", done_seq[0], 32'd89);
        finish_sq("R12");
    endtask

    initial begin
        trap_lat = 8'd1; thr_en = '0; rob_empty = '1;
        ex_seq = '0; ex_pc = '0; ins_seq = '0; cmt_seq = '0; rob_head = '0; arch_pc = '0;
        clear_pulses();
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle();
        t_exec();
        t_mispred();
        t_trap();
        t_tc_prio();
        t_tc_err();
        t_sa();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule